// File: doc/BRIEF.md
# Password Access Controller with Retry Lockout

This block decides whether a host may touch two protected memory arrays. A byte-level bus front end delivers each command as a single-cycle request: an 8-bit command code, a 64-bit candidate password and, for password-change commands, a 64-bit replacement value that the front end has already confirmed by double entry. The controller selects one of five stored 64-bit keys from the code: read and write keys for each array, and a master key. It compares the whole candidate against that key in one clock, keeps a count of failed attempts, and locks the arrays after too many failures.

Every accepted password attempt starts a busy window of `BUSY_CYCLES` clocks, whatever the outcome, so guesses cannot be tried faster than that. Requests that arrive during the window are refused. The host learns the verdict only by sending a poll command after the window has closed. Array-clear requests go out as single-cycle pulses to the array logic. The stored keys live in registers that reset to zero, and no port can read them out.

Top module: `pwd_gatekeeper`

## Requirements
- R1: After reset all five keys are zero, the failure count is zero, `locked`, `busy`, `grant` and `rsp_valid` are low. A first command that presents an all-zero password succeeds.
- R2: The legal codes are 80h/88h (read array 0/1), 90h/98h (write array 0/1), A0h/A8h/B0h/B8h/C0h (change read0/read1/write0/write1/master key), E0h (master wipe), E8h (unlock) and F0h (poll). Any other code gets `rsp_valid`=1 with `rsp_ack`=0 on the next cycle. It starts no busy window and changes no state.
- R3: A legal non-poll code received while idle gets `rsp_ack`=1 on the next cycle. `busy` is then high for exactly `BUSY_CYCLES` cycles. A request of any kind that arrives while `busy` is high gets `rsp_ack`=0 and is otherwise ignored.
- R4: A poll (F0h) received while idle gets `rsp_ack`=1 only if the most recent password attempt succeeded. Otherwise it gets `rsp_ack`=0.
- R5: A successful array command sets the one-hot output `grant` (bit0 read 0, bit1 read 1, bit2 write 0, bit3 write 1). `grant` is visible only while `busy` is low and is cleared by the next accepted non-poll command. A success also clears the failure count.
- R6: Each failed attempt increments the failure count, whichever key was tried. The `MAX_TRIES`-th failure without an intervening success raises `locked` and pulses `clr_arrays` for one cycle.
- R7: While `locked` is high, every command except E0h and E8h fails even with the correct key, does not count as a failure, and leaves the keys unchanged.
- R8: E8h with the correct master key clears the failure count and `locked`. It does not pulse `clr_arrays` and leaves all keys unchanged.
- R9: E0h with the correct master key pulses `clr_arrays`, sets all five keys to zero, and clears the failure count and `locked`.
- R10: A change command checks the current value of the key it names. On success that key takes the replacement value. On failure the key is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_code | input | 8 | Command code |
| req_pwd | input | PWD_W | Candidate password |
| req_newpwd | input | PWD_W | Replacement key for change commands |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_ack | output | 1 | Acknowledge (1) or refusal (0) |
| busy | output | 1 | Post-attempt busy window active |
| grant | output | 4 | One-hot array access granted |
| locked | output | 1 | Lockout after repeated failures |
| clr_arrays | output | 1 | One-cycle request to clear both arrays |

## Verification
The bench hunts for off-by-one errors in the lockout threshold. A design that trips on the seventh or ninth failure shows `clr_arrays` on the wrong attempt. It polls inside the busy window, where a design that leaks the verdict early would acknowledge. It also presents correct keys while locked; a faulty design grants access or keeps counting there. Key changes and the master wipe are checked through later attempts with the old and new keys, because the keys cannot be read. Mixed random traffic then exercises counts that reset on success across different keys.

// File: rtl/pga_pkg.sv
// Shared codes, slot indices and decoded-command type for the gatekeeper.
// Assumes five key slots; slot order matches the grant bit order.
package pga_pkg;
    localparam int NUM_SLOTS = 5;
    localparam int SLOT_W    = 3;
    localparam int ARR_W     = 4;

    localparam logic [SLOT_W-1:0] SLOT_RD0 = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_RD1 = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_WR0 = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_WR1 = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_MST = 3'd4;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_ARRAY  = 3'd1,
        OP_CHANGE = 3'd2,
        OP_WIPE   = 3'd3,
        OP_UNLOCK = 3'd4,
        OP_POLL   = 3'd5
    } op_e;

    typedef struct packed {
        logic              legal;
        op_e               op;
        logic [SLOT_W-1:0] slot;
    } dec_t;
endpackage

// File: rtl/pga_decode.sv
// Command decoder: maps an 8-bit code to an operation class and key slot.
// Purely combinational; unknown codes come out with legal = 0.
module pga_decode
    import pga_pkg::*;
(
    input  logic [7:0] code,
    output dec_t       dec
);
    // Map each legal code to its class and key slot.
    always_comb begin
        dec = '{legal: 1'b1, op: OP_NONE, slot: SLOT_MST};
        unique case (code)
            8'h80: begin dec.op = OP_ARRAY;  dec.slot = SLOT_RD0; end
            8'h88: begin dec.op = OP_ARRAY;  dec.slot = SLOT_RD1; end
            8'h90: begin dec.op = OP_ARRAY;  dec.slot = SLOT_WR0; end
            8'h98: begin dec.op = OP_ARRAY;  dec.slot = SLOT_WR1; end
            8'hA0: begin dec.op = OP_CHANGE; dec.slot = SLOT_RD0; end
            8'hA8: begin dec.op = OP_CHANGE; dec.slot = SLOT_RD1; end
            8'hB0: begin dec.op = OP_CHANGE; dec.slot = SLOT_WR0; end
            8'hB8: begin dec.op = OP_CHANGE; dec.slot = SLOT_WR1; end
            8'hC0: begin dec.op = OP_CHANGE; dec.slot = SLOT_MST; end
            8'hE0: dec.op = OP_WIPE;
            8'hE8: dec.op = OP_UNLOCK;
            8'hF0: dec.op = OP_POLL;
            default: dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/pga_vault.sv
// Key store: NUM_SLOTS registers of PWD_W bits, all zero at reset.
// Provides a full-width single-cycle match against the selected slot.
// Assumes wr_en and zero_all are never high together.
module pga_vault
    import pga_pkg::*;
#(
    parameter int PWD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] sel_slot,
    input  logic [PWD_W-1:0]  cand,
    input  logic              wr_en,
    input  logic [PWD_W-1:0]  wr_data,
    input  logic              zero_all,
    output logic              match
);
    logic [PWD_W-1:0] keys [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Hold one key; zero on reset or wipe, load on a verified change.
        always_ff @(posedge clk) begin
            if (!rst_n || zero_all)
                keys[s] <= '0;
            else if (wr_en && sel_slot == SLOT_W'(s))
                keys[s] <= wr_data;
        end
    end

    // Compare the whole candidate against the selected key.
    always_comb begin
        match = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++)
            if (sel_slot == SLOT_W'(s))
                match = (keys[s] == cand);
    end
endmodule

// File: rtl/pga_retry.sv
// Failure counter with lockout. trip is a combinational one-cycle flag
// on the failure that reaches MAX_TRIES. A success clears count and lock.
module pga_retry #(
    parameter int MAX_TRIES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail,
    input  logic success,
    output logic locked,
    output logic trip
);
    localparam int CNT_W = $clog2(MAX_TRIES + 1);
    logic [CNT_W-1:0] fails;

    // Flag the failure that reaches the limit.
    always_comb trip = fail && (fails == CNT_W'(MAX_TRIES - 1));

    // Track failures and the lock state.
    always_ff @(posedge clk) begin
        if (!rst_n || success) begin
            fails  <= '0;
            locked <= 1'b0;
        end else if (trip) begin
            fails  <= '0;
            locked <= 1'b1;
        end else if (fail) begin
            fails  <= fails + 1'b1;
        end
    end
endmodule

// File: rtl/pga_busy.sv
// Busy window timer: on load, stays busy for exactly BUSY_CYCLES cycles.
module pga_busy #(
    parameter int BUSY_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    logic [CNT_W-1:0] left;

    // Count the remaining cycles of the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left <= '0;
        else if (load)
            left <= CNT_W'(BUSY_CYCLES);
        else if (left != '0)
            left <= left - 1'b1;
    end

    // Busy while any cycles remain.
    always_comb busy = (left != '0);
endmodule

// File: rtl/pwd_gatekeeper.sv
// Password access controller. Takes one decoded request per cycle from a
// bus front end, verifies it against the stored keys, runs the retry
// lockout and the busy window, and reports a registered response one
// cycle later. Assumes the front end has already confirmed replacement keys.
module pwd_gatekeeper
    import pga_pkg::*;
#(
    parameter int PWD_W       = 64,
    parameter int MAX_TRIES   = 8,
    parameter int BUSY_CYCLES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_code,
    input  logic [PWD_W-1:0] req_pwd,
    input  logic [PWD_W-1:0] req_newpwd,
    output logic             rsp_valid,
    output logic             rsp_ack,
    output logic             busy,
    output logic [ARR_W-1:0] grant,
    output logic             locked,
    output logic             clr_arrays
);
    dec_t             dec;
    logic             match;
    logic             accept;
    logic             is_poll;
    logic             reset_op;
    logic             success;
    logic             fail_cnt;
    logic             trip;
    logic             last_ok;
    logic [ARR_W-1:0] sess_grant;

    pga_decode u_decode (
        .code (req_code),
        .dec  (dec)
    );

    // Classify the request against the current busy and lock state.
    always_comb begin
        is_poll  = req_valid && !busy && dec.legal && dec.op == OP_POLL;
        accept   = req_valid && !busy && dec.legal && dec.op != OP_POLL;
        reset_op = (dec.op == OP_WIPE) || (dec.op == OP_UNLOCK);
        success  = accept && match && (!locked || reset_op);
        fail_cnt = accept && !success && !locked;
    end

    pga_vault #(.PWD_W(PWD_W)) u_vault (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_slot (dec.slot),
        .cand     (req_pwd),
        .wr_en    (success && dec.op == OP_CHANGE),
        .wr_data  (req_newpwd),
        .zero_all (success && dec.op == OP_WIPE),
        .match    (match)
    );

    pga_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .fail    (fail_cnt),
        .success (success),
        .locked  (locked),
        .trip    (trip)
    );

    pga_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .busy  (busy)
    );

    // Register the response, the clear pulse and the last verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_ack    <= 1'b0;
            clr_arrays <= 1'b0;
            last_ok    <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_ack    <= accept || (is_poll && last_ok);
            clr_arrays <= trip || (success && dec.op == OP_WIPE);
            if (accept)
                last_ok <= success;
        end
    end

    // Hold the granted array until the next accepted attempt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sess_grant <= '0;
        else if (accept)
            sess_grant <= (success && dec.op == OP_ARRAY)
                          ? ARR_W'(1) << dec.slot : '0;
    end

    // Show the grant only once the busy window has closed.
    always_comb grant = busy ? '0 : sess_grant;
endmodule

// File: rtl/pga_checker.sv
// Property checker for pwd_gatekeeper, attached by bind below.
module pga_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [7:0] req_code,
    input logic       accept,
    input logic       busy,
    input logic       rsp_ack,
    input logic [3:0] grant,
    input logic       locked,
    input logic       clr_arrays
);
    assert_busy_after_attempt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    assert_refuse_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> !rsp_ack);

    assert_poll_ack_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_code == 8'hF0 && busy) |=> !rsp_ack);

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_lock_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> clr_arrays);

    assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !req_valid) |=> locked);
endmodule

bind pwd_gatekeeper pga_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_code   (req_code),
    .accept     (accept),
    .busy       (busy),
    .rsp_ack    (rsp_ack),
    .grant      (grant),
    .locked     (locked),
    .clr_arrays (clr_arrays)
);

// File: tb/pwd_gatekeeper_tb.sv
module pwd_gatekeeper_tb;
    localparam int PWD_W = 64;
    localparam int MAXT  = 8;
    localparam int BUSYC = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [7:0]       req_code = '0;
    logic [PWD_W-1:0] req_pwd = '0;
    logic [PWD_W-1:0] req_newpwd = '0;
    logic             rsp_valid, rsp_ack, busy, locked, clr_arrays;
    logic [3:0]       grant;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [PWD_W-1:0] m_key [5];
    int               m_cnt;
    bit               m_lock, m_ok;
    logic [3:0]       m_grant;

    always #4 clk = ~clk;

    pwd_gatekeeper #(.PWD_W(PWD_W), .MAX_TRIES(MAXT), .BUSY_CYCLES(BUSYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .req_pwd(req_pwd), .req_newpwd(req_newpwd), .rsp_valid(rsp_valid),
        .rsp_ack(rsp_ack), .busy(busy), .grant(grant), .locked(locked),
        .clr_arrays(clr_arrays)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Operation class from the code table in R2: 0 illegal, 1 array,
    // 2 change, 3 wipe, 4 unlock, 5 poll.
    function automatic int op_of(logic [7:0] c);
        case (c)
            8'h80, 8'h88, 8'h90, 8'h98: return 1;
            8'hA0, 8'hA8, 8'hB0, 8'hB8, 8'hC0: return 2;
            8'hE0: return 3;
            8'hE8: return 4;
            8'hF0: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic int slot_of(logic [7:0] c);
        case (c)
            8'h80, 8'hA0: return 0;
            8'h88, 8'hA8: return 1;
            8'h90, 8'hB0: return 2;
            8'h98, 8'hB8: return 3;
            default: return 4;
        endcase
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0: return "R2";
            1: return "R5";
            2: return "R10";
            3: return "R9";
            4: return "R8";
            default: return "R4";
        endcase
    endfunction

    // Issue one request while idle, check the response, wait out busy.
    task automatic cmd(logic [7:0] c, logic [63:0] p, logic [63:0] np);
        int  op = op_of(c);
        int  sl = slot_of(c);
        bit  e_ack, e_clr, ok;
        string t = tag_of(op);
        e_clr = 0;
        if (op == 0) e_ack = 0;
        else if (op == 5) e_ack = m_ok;
        else begin
            e_ack = 1;
            ok = (m_key[sl] == p) && (!m_lock || op == 3 || op == 4);
            if (ok) begin
                m_cnt = 0; m_lock = 0; m_ok = 1;
                m_grant = (op == 1) ? 4'(1 << sl) : 4'd0;
                if (op == 2) m_key[sl] = np;
                if (op == 3) begin
                    for (int k = 0; k < 5; k++) m_key[k] = '0;
                    e_clr = 1;
                end
            end else begin
                m_ok = 0; m_grant = '0;
                if (!m_lock) begin
                    m_cnt++;
                    if (m_cnt == MAXT) begin m_lock = 1; m_cnt = 0; e_clr = 1; t = "R6"; end
                end else t = "R7";
            end
        end
        @(negedge clk);
        req_valid = 1; req_code = c; req_pwd = p; req_newpwd = np;
        @(negedge clk);
        req_valid = 0;
        chk({t, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({t, " rsp_ack"}, 64'(rsp_ack), 64'(e_ack));
        chk({e_clr ? "R6/R9" : t, " clr_arrays"}, 64'(clr_arrays), 64'(e_clr));
        chk({m_lock ? "R6" : "R8", " locked"}, 64'(locked), 64'(m_lock));
        if (op == 0 || op == 5) begin
            chk("R2 no busy for poll/illegal", 64'(busy), 64'd0);
        end else begin
            repeat (BUSYC - 1) @(posedge clk);
            @(negedge clk);
            chk("R3 busy held", 64'(busy), 64'd1);
            chk("R5 grant hidden while busy", 64'(grant), 64'd0);
            @(posedge clk);
            @(negedge clk);
            chk("R3 busy ends", 64'(busy), 64'd0);
        end
        chk("R5 grant", 64'(grant), 64'(m_grant));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] nk;
        for (int k = 0; k < 5; k++) m_key[k] = '0;
        m_cnt = 0; m_lock = 0; m_ok = 0; m_grant = '0;
        void'($urandom(32'h1357));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 64'(busy), 0);
        chk("R1 locked", 64'(locked), 0);
        chk("R1 grant", 64'(grant), 0);
        chk("R1 rsp_valid", 64'(rsp_valid), 0);
        // R1 zero key accepted; R4 poll acknowledges
        cmd(8'h80, 64'h0, 64'h0);
        cmd(8'hF0, 64'h0, 64'h0);
        // R3 poll during busy refused and ignored
        @(negedge clk);
        req_valid = 1; req_code = 8'h98; req_pwd = 64'h1;
        @(negedge clk);
        req_code = 8'hF0;
        @(negedge clk);
        req_valid = 0;
        chk("R3 refused while busy", 64'(rsp_ack), 0);
        m_ok = 0; m_cnt = 1; m_grant = '0;
        repeat (BUSYC + 1) @(negedge clk);
        cmd(8'hF0, 64'h0, 64'h0);
        // R2 illegal code
        cmd(8'h81, 64'h0, 64'h0);
        cmd(8'h00, 64'h0, 64'h0);
        // R10 change read0 key then use old and new
        nk = 64'hDEAD_BEEF_0123_4567;
        cmd(8'hA0, 64'h0, nk);
        cmd(8'h80, 64'h0, 64'h0);
        cmd(8'hF0, 64'h0, 64'h0);
        cmd(8'h80, nk, 64'h0);
        // R6 eight failures lock; R7 correct key refused while locked
        for (int i = 0; i < MAXT; i++) cmd(8'h90, 64'h55, 64'h0);
        cmd(8'h80, nk, 64'h0);
        cmd(8'hF0, 64'h0, 64'h0);
        cmd(8'hA8, 64'h0, 64'h99);
        // R8 unlock keeps keys
        cmd(8'hE8, 64'h0, 64'h0);
        cmd(8'h80, nk, 64'h0);
        // R9 wipe zeroes keys
        cmd(8'hE0, 64'h0, 64'h0);
        cmd(8'h80, 64'h0, 64'h0);
        // Mixed random traffic
        for (int i = 0; i < 300; i++) begin
            logic [7:0] codes [14] = '{8'h80, 8'h88, 8'h90, 8'h98, 8'hA0, 8'hA8,
                8'hB0, 8'hB8, 8'hC0, 8'hE0, 8'hE8, 8'hF0, 8'h8A, 8'hFF};
            logic [7:0] c = codes[$urandom % 14];
            logic [63:0] p = ($urandom % 3 != 0) ? m_key[slot_of(c)]
                                                 : {32'($urandom), 32'($urandom)};
            logic [63:0] q = 64'($urandom % 4);
            cmd(c, p, q);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule